// File: doc/BRIEF.md
# GPIO Port Configuration with Wake Detection

This block holds the configuration state for one 8-bit general-purpose I/O port and watches its pins for a wake-up event. Software does not see the configuration sub-registers directly. It first writes an index into an address register, then reads or writes the selected sub-register through a single control data window. Three sub-registers are implemented: a high-drive select, a wake-source enable and a pull-up enable. Each one is driven out as an 8-bit per-pin control vector toward the pad ring.

While the power controller holds the stop-mode flag, the block compares the synchronised pin levels cycle by cycle. Any level change, rising or falling, on a pin whose wake-source enable bit is set raises a sticky recovery request. The request stays high until the power controller drops the stop-mode flag. Pins pass through a two-flop synchroniser before they are compared. The level seen at stop entry is the baseline, so entering stop never produces an event by itself.

Top module: `gpio_port_cfg`

## Requirements
- R1: After reset, the address register, all three sub-registers and `wake_req_o` read 0.
- R2: A cycle with `addr_we_i` high loads `wdata_i` into the address register. `addr_rdata_o` shows the stored value unchanged from the next cycle on.
- R3: Index 04h selects the high-drive sub-register. A control write sets `high_drive_o` in the next cycle, and `ctl_rdata_o` returns the stored value. Bit n = 1 selects high drive for pin n; 0 selects standard drive.
- R4: Index 05h selects the wake-source enable sub-register, which is read/write through the control window.
- R5: Index 06h selects the pull-up enable sub-register. Bit n = 1 drives `pull_up_o[n]` high, and the stored value reads back through `ctl_rdata_o`.
- R6: With any other index in the address register, `ctl_rdata_o` reads 00h and control writes change no sub-register.
- R7: Pin inputs pass two synchroniser flops. A wake event on a pin that changes before rising edge k shows on `wake_req_o` after rising edge k+2.
- R8: During stop mode, a rising or a falling level change on a pin with its wake-source enable bit at 1 asserts `wake_req_o`.
- R9: During stop mode, level changes on pins with their enable bit at 0 never assert `wake_req_o`.
- R10: Entering stop mode with settled pins, whatever their levels, does not assert `wake_req_o`.
- R11: Once asserted, `wake_req_o` stays high while `stop_mode_i` is high, including after the pin returns. It falls at the first rising edge with `stop_mode_i` low, and it stays low whenever stop mode is off, even when enabled pins toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_we_i | input | 1 | Write strobe for the address register |
| ctl_we_i | input | 1 | Write strobe for the control data window |
| wdata_i | input | 8 | Write data for either register |
| addr_rdata_o | output | 8 | Address register contents |
| ctl_rdata_o | output | 8 | Contents of the sub-register selected by the address register |
| pin_i | input | 8 | Asynchronous pin input levels |
| stop_mode_i | input | 1 | Stop-mode flag from the power controller |
| high_drive_o | output | 8 | Per-pin high-drive select |
| pull_up_o | output | 8 | Per-pin weak pull-up enable |
| wake_req_o | output | 1 | Sticky stop-mode recovery request |

## Verification
The hardest situation to reach from the ports is telling a genuine pin edge during stop mode apart from an edge that is only an artefact of stop entry or of the synchroniser delay. The bench changes pins while stop mode is off and lets them settle. It then raises stop mode and holds it for several cycles to show that no event appears. Only after that does it toggle single enabled or disabled pins, sampling exactly three edges after each change. It also returns a pin to its old level to show that the request holds until stop mode is dropped.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  localparam int unsigned SUB_BASE  = 4;  // index of first sub-register
  localparam int unsigned SUB_COUNT = 3;
  localparam int unsigned SUB_HDRV  = 0;  // slot = index - SUB_BASE
  localparam int unsigned SUB_WAKE  = 1;
  localparam int unsigned SUB_PULL  = 2;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_cfg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_we_i,
  input  logic          ctl_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] ctl_rdata_o,
  output logic [DW-1:0] hdrv_o,
  output logic [DW-1:0] wake_en_o,
  output logic [DW-1:0] pull_o
);
  localparam int unsigned NSUB = SUB_COUNT;

  logic [DW-1:0]            addr_q;
  logic [NSUB-1:0][DW-1:0]  sub_q;
  logic [NSUB-1:0]          sel;
  logic                     hit;

  for (genvar g = 0; g < NSUB; g++) begin : g_sel
    assign sel[g] = (addr_q == DW'(SUB_BASE + g));
  end
  assign hit = |sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (addr_we_i) addr_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
    end else if (ctl_we_i) begin
      for (int i = 0; i < NSUB; i++)
        if (sel[i]) sub_q[i] <= wdata_i;
    end
  end

  always_comb begin
    ctl_rdata_o = '0;
    for (int i = 0; i < NSUB; i++)
      if (sel[i]) ctl_rdata_o = ctl_rdata_o | sub_q[i];
  end

  assign addr_o    = addr_q;
  assign hdrv_o    = sub_q[SUB_HDRV];
  assign wake_en_o = sub_q[SUB_WAKE];
  assign pull_o    = sub_q[SUB_PULL];

  p_bad_index_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !hit) |=> $stable(sub_q));
  p_pull_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && addr_q == DW'(SUB_BASE + SUB_PULL)) |=> (pull_o == $past(wdata_i)));
  p_addr_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_we_i |=> (addr_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_wake_det.sv
module gpio_wake_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_s_i,
  input  logic [W-1:0] en_i,
  input  logic         stop_i,
  output logic         req_o
);
  logic [W-1:0] prev_q;
  logic         stop_q;
  logic         req_q;
  logic         event_hit;

  // first stop cycle is the baseline: stop_q still low there
  assign event_hit = stop_i && stop_q && |((pin_s_i ^ prev_q) & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stop_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      stop_q <= stop_i;
      if (!stop_i)        req_q <= 1'b0;
      else if (event_hit) req_q <= 1'b1;
    end
  end

  assign req_o = req_q;

  p_no_wake_outside_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> !req_o);
  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && stop_i) |=> req_o);
  p_entry_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_i) |=> !req_o);
endmodule

// File: rtl/gpio_port_cfg.sv
module gpio_port_cfg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       addr_we_i,
  input  logic       ctl_we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] addr_rdata_o,
  output logic [7:0] ctl_rdata_o,
  input  logic [7:0] pin_i,
  input  logic       stop_mode_i,
  output logic [7:0] high_drive_o,
  output logic [7:0] pull_up_o,
  output logic       wake_req_o
);
  localparam int unsigned DW = 8;

  logic [DW-1:0] wake_en;
  logic [DW-1:0] pin_s;

  gpio_cfg_regs #(.DW(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_we_i   (addr_we_i),
    .ctl_we_i    (ctl_we_i),
    .wdata_i     (wdata_i),
    .addr_o      (addr_rdata_o),
    .ctl_rdata_o (ctl_rdata_o),
    .hdrv_o      (high_drive_o),
    .wake_en_o   (wake_en),
    .pull_o      (pull_up_o)
  );

  gpio_pin_sync #(.W(DW)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  gpio_wake_det #(.W(DW)) u_wake (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_s_i (pin_s),
    .en_i    (wake_en),
    .stop_i  (stop_mode_i),
    .req_o   (wake_req_o)
  );

  p_wake_needs_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_req_o) |-> $past(stop_mode_i));
  p_disabled_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_mode_i && wake_en == '0 && !wake_req_o) |=> !wake_req_o);
endmodule

// File: tb/gpio_port_cfg_bench.sv
module gpio_port_cfg_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       addr_we_i = 1'b0;
  logic       ctl_we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] pin_i = '0;
  logic       stop_mode_i = 1'b0;
  logic [7:0] addr_rdata_o, ctl_rdata_o, high_drive_o, pull_up_o;
  logic       wake_req_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_cfg u_gpio_port_cfg (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .addr_we_i    (addr_we_i),
    .ctl_we_i     (ctl_we_i),
    .wdata_i      (wdata_i),
    .addr_rdata_o (addr_rdata_o),
    .ctl_rdata_o  (ctl_rdata_o),
    .pin_i        (pin_i),
    .stop_mode_i  (stop_mode_i),
    .high_drive_o (high_drive_o),
    .pull_up_o    (pull_up_o),
    .wake_req_o   (wake_req_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_addr(input logic [7:0] v);
    @(negedge clk); addr_we_i = 1'b1; wdata_i = v;
    @(negedge clk); addr_we_i = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we_i = 1'b1; wdata_i = v;
    @(negedge clk); ctl_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 addr", addr_rdata_o, 8'h00);
    chk("R1 hdrv", high_drive_o, 8'h00);
    chk("R1 pull", pull_up_o, 8'h00);
    chk("R1 wake", {7'b0, wake_req_o}, 8'h00);
    wr_addr(8'h05);
    chk("R1 wake_en", ctl_rdata_o, 8'h00);
  endtask

  task automatic t_addr;
    wr_addr(8'hA7);
    chk("R2 addr", addr_rdata_o, 8'hA7);
    wr_addr(8'h3C);
    chk("R2 addr", addr_rdata_o, 8'h3C);
  endtask

  task automatic t_subregs;
    wr_addr(8'h04); wr_ctl(8'h5A);
    chk("R3 hdrv out", high_drive_o, 8'h5A);
    chk("R3 hdrv read", ctl_rdata_o, 8'h5A);
    wr_addr(8'h05); wr_ctl(8'hC3);
    chk("R4 wake_en read", ctl_rdata_o, 8'hC3);
    chk("R4 hdrv kept", high_drive_o, 8'h5A);
    wr_addr(8'h06); wr_ctl(8'h81);
    chk("R5 pull out", pull_up_o, 8'h81);
    chk("R5 pull read", ctl_rdata_o, 8'h81);
  endtask

  task automatic t_bad_index;
    wr_addr(8'h07); wr_ctl(8'hFF);
    chk("R6 read 07", ctl_rdata_o, 8'h00);
    wr_addr(8'h00); wr_ctl(8'hFF);
    chk("R6 read 00", ctl_rdata_o, 8'h00);
    chk("R6 hdrv kept", high_drive_o, 8'h5A);
    chk("R6 pull kept", pull_up_o, 8'h81);
    wr_addr(8'h05);
    chk("R6 wake_en kept", ctl_rdata_o, 8'hC3);
  endtask

  // wake enable = 8'h01 for the rest
  task automatic t_entry;
    wr_addr(8'h05); wr_ctl(8'h01);
    pin_i = 8'h00; cyc(4);
    pin_i = 8'h01; cyc(4);          // toggle outside stop
    chk("R11 no wake outside stop", {7'b0, wake_req_o}, 8'h00);
    stop_mode_i = 1'b1; cyc(6);     // enter with enabled pin high
    chk("R10 entry quiet", {7'b0, wake_req_o}, 8'h00);
  endtask

  task automatic t_disabled;
    pin_i = 8'hF1; cyc(5);
    chk("R9 disabled pins", {7'b0, wake_req_o}, 8'h00);
  endtask

  task automatic t_fall_and_sticky;
    pin_i = 8'hF0;                  // enabled pin falls
    cyc(2);
    chk("R7 not yet", {7'b0, wake_req_o}, 8'h00);
    cyc(1);
    chk("R8 falling edge", {7'b0, wake_req_o}, 8'h01);
    pin_i = 8'hF1; cyc(4);
    chk("R11 sticky", {7'b0, wake_req_o}, 8'h01);
    stop_mode_i = 1'b0; cyc(1);
    chk("R11 clear", {7'b0, wake_req_o}, 8'h00);
  endtask

  task automatic t_rise;
    pin_i = 8'h00; cyc(4);
    stop_mode_i = 1'b1; cyc(4);
    chk("R10 entry low", {7'b0, wake_req_o}, 8'h00);
    pin_i = 8'h01;
    cyc(2);
    chk("R7 two edges", {7'b0, wake_req_o}, 8'h00);
    cyc(1);
    chk("R8 rising edge", {7'b0, wake_req_o}, 8'h01);
    stop_mode_i = 1'b0; cyc(1);
    chk("R11 clear rise", {7'b0, wake_req_o}, 8'h00);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset;
    t_addr;
    t_subregs;
    t_bad_index;
    t_entry;
    t_disabled;
    t_fall_and_sticky;
    t_rise;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule